// File: doc/BRIEF.md
# Terminal Transmit Register Port

A memory-mapped transmit port for a character terminal. It has two word locations on a 16-bit bus, chosen by address bit 1: a control/status word and a transmit data word. Software writes a character to the data word. The block then drops its ready flag and issues a one-cycle start pulse to an external serializer. The serializer answers with a one-cycle completion pulse. On that pulse the ready flag comes back, and an interrupt is raised if software has enabled it.

The serializer and the baud timing are outside the block. The character the serializer sees is cut to 7 or 8 bits, as set by a mode input. Only the low (even) byte lane carries implemented bits, so only that lane's data and strobe reach the block.

Top module: `tx_port_regs`

## Requirements
- R1: After reset the status word reads 0x0080 (ready set, enable clear), the data word reads 0x0000, and `irq`, `tx_busy` and `tx_start` are low.
- R2: The status word returns ready in bit 7 and interrupt enable in bit 6, with all other bits zero. Only bit 6 is writable, so a status write never changes ready.
- R3: A write to the data word clears ready and sets `tx_busy` on the next edge. It also pulses `tx_start` high for exactly one cycle after that edge.
- R4: A data-word write loads bits 7:0 only when the even lane strobe `wr_lo` is high. Without it the held byte is kept, but ready is still cleared and a transfer still starts.
- R5: A `tx_fin` pulse while busy sets ready and clears `tx_busy` on the next edge. A `tx_fin` pulse while idle has no effect.
- R6: `irq` is high exactly when ready and enable are both set. Enabling while ready raises it, clearing enable drops it, and a completion with enable set raises it.
- R7: A status write without the even lane strobe leaves the enable bit and `irq` unchanged.
- R8: Reading the data word returns the held byte in bits 7:0 and changes no state.
- R9: `tx_char` is the held byte when `mode8` is 1, and the held byte with bit 7 forced to 0 when `mode8` is 0.
- R10: A data-word write during a transfer restarts it with a new start pulse. A write wins over a `tx_fin` in the same cycle, so ready stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_buf | input | 1 | Address bit 1: 0 selects the status word, 1 selects the data word |
| wr_en | input | 1 | Write strobe for the selected word |
| wr_lo | input | 1 | Even (low) byte lane strobe |
| wdata | input | 8 | Low byte lane write data |
| rdata | output | 16 | Read data of the selected word |
| mode8 | input | 1 | 1 selects 8-bit characters, 0 selects 7-bit |
| irq | output | 1 | Interrupt request |
| tx_start | output | 1 | One-cycle pulse that starts a serializer transfer |
| tx_busy | output | 1 | A transfer is outstanding |
| tx_char | output | 8 | Masked character for the serializer |
| tx_fin | input | 1 | One-cycle completion pulse from the serializer |

## Verification
All 256 byte values go through a full transfer in both character modes. The completion delay changes with each value, so a design that masked the wrong bit, or finished a transfer on a fixed delay instead of on the completion pulse, would show a wrong character or a wrong latency. A design that loaded the byte on an odd-lane-only write, or that did not start a transfer for one, would emit a changed character or never become busy. A completion arriving together with a new write checks the write-wins rule; a design that got it wrong would show ready set with a transfer still pending. Enable, disable and odd-lane status writes are checked against `irq`; a design that latched the interrupt instead of deriving it from ready and enable would hold it high after enable was cleared.

// File: rtl/tx_port_regs.sv
module tx_port_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_buf,
  input  logic        wr_en,
  input  logic        wr_lo,
  input  logic [7:0]  wdata,
  output logic [15:0] rdata,
  input  logic        mode8,
  output logic        irq,
  output logic        tx_start,
  output logic        tx_busy,
  output logic [7:0]  tx_char,
  input  logic        tx_fin
);
  logic [7:0] hold;
  logic       done;
  logic       ie;

  wire buf_wr = wr_en & addr_buf;
  wire csr_wr = wr_en & ~addr_buf & wr_lo;
  wire fin_ok = tx_busy & tx_fin & ~buf_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= 8'h00;
      done     <= 1'b1;
      ie       <= 1'b0;
      tx_start <= 1'b0;
      tx_busy  <= 1'b0;
    end else begin
      tx_start <= buf_wr;
      if (buf_wr) begin
        if (wr_lo) hold <= wdata;
        done    <= 1'b0;
        tx_busy <= 1'b1;
      end else if (fin_ok) begin
        done    <= 1'b1;
        tx_busy <= 1'b0;
      end
      if (csr_wr) ie <= wdata[6];
    end
  end

  assign irq     = done & ie;
  assign rdata   = addr_buf ? {8'h00, hold} : {8'h00, done, ie, 6'b000000};
  assign tx_char = mode8 ? hold : {1'b0, hold[6:0]};
endmodule

// File: rtl/tx_port_regs_chk.sv
module tx_port_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_lo,
  input logic       addr_buf,
  input logic       wd6,
  input logic       tx_fin,
  input logic       tx_busy,
  input logic       tx_start,
  input logic       irq,
  input logic       done,
  input logic       ie,
  input logic [7:0] hold
);
  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_buf) |=> (tx_start && tx_busy && !done)); // R3
  AST_ODD_BUF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_buf && !wr_lo) |=> $stable(hold)); // R4
  AST_FIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_fin && !(wr_en && addr_buf)) |=> (done && !tx_busy)); // R5
  AST_IE_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_buf && wr_lo && !wd6) |=> !irq); // R6
  AST_ODD_CSR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_buf && !wr_lo) |=> $stable(ie)); // R7
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(tx_busy && tx_fin)) |=> ($stable(done) && $stable(hold))); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !done); // R10
endmodule

bind tx_port_regs tx_port_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo(wr_lo), .addr_buf(addr_buf),
  .wd6(wdata[6]), .tx_fin(tx_fin), .tx_busy(tx_busy), .tx_start(tx_start),
  .irq(irq), .done(done), .ie(ie), .hold(hold)
);

// File: tb/test_tx_port_regs.sv
module test_tx_port_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_buf = 1'b0, wr_en = 1'b0, wr_lo = 1'b0, mode8 = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [15:0] rdata;
  logic irq, tx_start, tx_busy, tx_fin;
  logic [7:0] tx_char;

  int checks = 0, fails = 0, cycles = 0;
  logic auto_en = 1'b1, man_fin = 1'b0;
  int wait_cfg = 1;
  int cnt = 0;
  logic [7:0] seen_char = 8'h00;
  int starts = 0;

  always #5 clk = ~clk;

  tx_port_regs i_tx_port_regs (
    .clk(clk), .rst_n(rst_n), .addr_buf(addr_buf), .wr_en(wr_en), .wr_lo(wr_lo),
    .wdata(wdata), .rdata(rdata), .mode8(mode8), .irq(irq), .tx_start(tx_start),
    .tx_busy(tx_busy), .tx_char(tx_char), .tx_fin(tx_fin)
  );

  assign tx_fin = man_fin || (auto_en && cnt == 1);

  always @(posedge clk) begin
    if (tx_start) begin
      cnt       <= wait_cfg;
      seen_char <= tx_char;
      starts    <= starts + 1;
    end else if (cnt > 0) cnt <= cnt - 1;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic ab, input logic lo, input logic [7:0] d);
    @(negedge clk);
    addr_buf = ab; wr_lo = lo; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic rd(input logic ab, output logic [15:0] v);
    addr_buf = ab;
    #1 v = rdata;
  endtask

  task automatic wait_ready(output int n);
    logic [15:0] v;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      rd(1'b0, v);
    end while (!v[7] && n < 60);
  endtask

  initial begin
    logic [15:0] v;
    int n;
    int st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk("R1 status", v, 16'h0080);
    rd(1'b1, v); chk("R1 data", v, 16'h0000);
    chk("R1 irq/busy/start", {irq, tx_busy, tx_start}, 0);

    bus_wr(1'b0, 1'b1, 8'hFF);
    rd(1'b0, v); chk("R2 status after 0xFF", v, 16'h00C0);
    chk("R6 enable while ready", irq, 1);
    bus_wr(1'b0, 1'b1, 8'h00);
    rd(1'b0, v); chk("R2 ready not writable", v, 16'h0080);
    chk("R6 clear enable drops", irq, 0);
    bus_wr(1'b0, 1'b0, 8'h40);
    rd(1'b0, v); chk("R7 odd status write", v, 16'h0080);
    chk("R7 irq unchanged", irq, 0);
    bus_wr(1'b0, 1'b1, 8'h40);
    chk("R6 irq up", irq, 1);

    for (int m = 0; m < 2; m++) begin
      mode8 = m[0];
      for (int b = 0; b < 256; b++) begin
        wait_cfg = (b % 5) + 1;
        bus_wr(1'b1, 1'b1, b[7:0]);
        rd(1'b0, v);
        chk("R3 ready cleared", {v[7], tx_busy, irq}, 3'b010);
        wait_ready(n);
        chk("R5 completion latency", n, wait_cfg + 1);
        chk("R9 emitted char", seen_char, m ? b : (b & 8'h7F));
        chk("R6 irq on completion", {irq, tx_busy}, 2'b10);
        rd(1'b1, v); chk("R8 data read", v, b);
      end
    end

    mode8 = 1'b1;
    bus_wr(1'b1, 1'b1, 8'hA5);
    wait_ready(n);
    st = starts;
    bus_wr(1'b1, 1'b0, 8'h3C);
    rd(1'b0, v); chk("R4 odd write starts", {v[7], tx_busy}, 2'b01);
    wait_ready(n);
    chk("R4 odd write keeps byte", seen_char, 8'hA5);
    chk("R3 one start per write", starts - st, 1);
    rd(1'b1, v); chk("R4 held byte", v, 16'h00A5);

    @(negedge clk); man_fin = 1'b1;
    @(negedge clk); man_fin = 1'b0;
    rd(1'b0, v); chk("R5 idle fin ignored", {v[7], tx_busy}, 2'b10);

    auto_en = 1'b0;
    bus_wr(1'b1, 1'b1, 8'h11);
    repeat (3) begin
      rd(1'b1, v); @(negedge clk);
    end
    rd(1'b0, v); chk("R8 read no side effect", {v[7], tx_busy}, 2'b01);
    chk("R3 start is one pulse", tx_start, 0);
    st = starts;
    @(negedge clk);
    addr_buf = 1'b1; wr_lo = 1'b1; wdata = 8'h22; wr_en = 1'b1; man_fin = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_lo = 1'b0; man_fin = 1'b0;
    rd(1'b0, v); chk("R10 write beats fin", {v[7], tx_busy, irq}, 3'b010);
    @(negedge clk);
    chk("R10 restart pulse", starts - st, 1);
    chk("R10 new char", seen_char, 8'h22);
    man_fin = 1'b1;
    @(negedge clk); man_fin = 1'b0;
    rd(1'b0, v); chk("R5 manual fin", {v[7], tx_busy, irq}, 3'b101);

    rst_n = 1'b0;
    bus_wr(1'b1, 1'b1, 8'h77);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk("R1 reset again", v, 16'h0080);
    rd(1'b1, v); chk("R1 data cleared", v, 16'h0000);
    finish_run();
  end
endmodule